// File: doc/BRIEF.md
# GPIO Interrupt Controller

This block is a bank of general-purpose pins behind a simple word-wide register bus with an address, a write strobe, write data and a combinational read-data return. Software drives output pins through an output data word. Two alias addresses let it raise or drop individual output bits without a read-modify-write. A direction word decides, pin by pin, whether the pad is driven. Every pin is sampled through a synchronizer, whatever its direction, and the sampled value can be read back.

Each pin can also raise an interrupt. Three per-pin configuration bits choose the trigger: a level sense of either polarity, a single edge of either polarity, or any edge. Edge events are latched until software acknowledges them by writing ones to a clear address. Level status follows the pin. An enable word gates which pins may report status at all. A mask word removes pins from the single combined interrupt line while their status stays readable, so a handler can scan the status word bit by bit. The pull control and debounce words are plain storage and have no effect on the pins.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every stored word reads as zero, the status word reads zero and `irq_out` is low.
- R2: A write to offset 0x00 loads the output data word, and a read of 0x00 returns it. The word changes only on a bus write.
- R3: Writing offset 0x10 sets each output data bit whose write bit is 1. Writing offset 0x14 clears each output data bit whose write bit is 1. Every other bit keeps its value, and `pin_out` always equals the output data word.
- R4: The direction word at offset 0x08 drives `pin_oe` bit for bit, where 1 means the pin is driven.
- R5: A read of offset 0x04 returns each pin's input value after two clock edges of synchronization, for every pin whatever its direction.
- R6: A trigger-type bit of 1 (offset 0x34) selects level sense. Polarity bit 0 (offset 0x3C) means active high and 1 means active low. Level status follows the synchronized pin and is not held.
- R7: A trigger-type bit of 0 with any-edge bit 0 (offset 0x38) selects a single edge: rising when polarity is 0, falling when polarity is 1. A detected edge stays in the status word (offset 0x24) until it is cleared.
- R8: A trigger-type bit of 0 with any-edge bit 1 latches on either edge, and the polarity bit is ignored.
- R9: Writing 1 to a bit of offset 0x30 clears that pin's latched edge. Writing 0 has no effect. When a new edge arrives in the same cycle as the clear, the edge is kept.
- R10: A pin whose enable bit (offset 0x20) is 0 never sets its status, and an edge seen while it was disabled is not reported after it is enabled.
- R11: `irq_out` is high exactly when some pin has status, enable 1 and mask bit (offset 0x2C) 0. A masked pin's status still reads back.
- R12: The words at offsets 0x18, 0x1C, 0x40 and 0x44 store and return written data and do not affect any pin or the interrupt. Reads of 0x10, 0x14 and 0x30 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Raw pad input values |
| pin_out | output | NUM_PINS | Pad output values |
| pin_oe | output | NUM_PINS | Pad output enables, 1 drives the pad |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: 32 pins on a 32-bit data word, an 8-bit address and a two-stage synchronizer. This way every bit of every word, including the top bits of the alias writes, maps to a real pin. The two-stage depth makes the input latency exact, so the bench can check that a pin change is still invisible one edge after it happens and visible after the second. The same timing lets an edge and its acknowledge be placed in one cycle on purpose, to test the case where the new edge must be kept.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   typedef enum logic [4:0] {
      SEL_NONE,
      SEL_OUT,
      SEL_IN,
      SEL_DIR,
      SEL_SET,
      SEL_CLR,
      SEL_PEN,
      SEL_PTYP,
      SEL_IEN,
      SEL_ISTAT,
      SEL_IMASK,
      SEL_ICLR,
      SEL_ITYPE,
      SEL_IBOTH,
      SEL_IPOL,
      SEL_DEN,
      SEL_DPRE
   } gsel_e;

   // word offsets of the register map
   localparam logic [15:0] OFS_OUT   = 16'h0000;
   localparam logic [15:0] OFS_IN    = 16'h0004;
   localparam logic [15:0] OFS_DIR   = 16'h0008;
   localparam logic [15:0] OFS_SET   = 16'h0010;
   localparam logic [15:0] OFS_CLR   = 16'h0014;
   localparam logic [15:0] OFS_PEN   = 16'h0018;
   localparam logic [15:0] OFS_PTYP  = 16'h001C;
   localparam logic [15:0] OFS_IEN   = 16'h0020;
   localparam logic [15:0] OFS_ISTAT = 16'h0024;
   localparam logic [15:0] OFS_IMASK = 16'h002C;
   localparam logic [15:0] OFS_ICLR  = 16'h0030;
   localparam logic [15:0] OFS_ITYPE = 16'h0034;
   localparam logic [15:0] OFS_IBOTH = 16'h0038;
   localparam logic [15:0] OFS_IPOL  = 16'h003C;
   localparam logic [15:0] OFS_DEN   = 16'h0040;
   localparam logic [15:0] OFS_DPRE  = 16'h0044;

   function automatic gsel_e decode_addr(input logic [15:0] a);
      gsel_e s;
      case (a)
         OFS_OUT:   s = SEL_OUT;
         OFS_IN:    s = SEL_IN;
         OFS_DIR:   s = SEL_DIR;
         OFS_SET:   s = SEL_SET;
         OFS_CLR:   s = SEL_CLR;
         OFS_PEN:   s = SEL_PEN;
         OFS_PTYP:  s = SEL_PTYP;
         OFS_IEN:   s = SEL_IEN;
         OFS_ISTAT: s = SEL_ISTAT;
         OFS_IMASK: s = SEL_IMASK;
         OFS_ICLR:  s = SEL_ICLR;
         OFS_ITYPE: s = SEL_ITYPE;
         OFS_IBOTH: s = SEL_IBOTH;
         OFS_IPOL:  s = SEL_IPOL;
         OFS_DEN:   s = SEL_DEN;
         OFS_DPRE:  s = SEL_DPRE;
         default:   s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_i,
   output logic [WIDTH-1:0] sync_o,
   output logic [WIDTH-1:0] prev_o
);

   logic [WIDTH-1:0] tap [STAGES+1];
   logic [WIDTH-1:0] prev_q;

   assign tap[0] = pin_i;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= '0;
         else        q_r <= tap[s];
      end
      assign tap[s+1] = q_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= tap[STAGES];
   end

   assign sync_o = tap[STAGES];
   assign prev_o = prev_q;

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
   parameter int NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] sync_i,
   input  logic [NUM_PINS-1:0] prev_i,
   input  logic [NUM_PINS-1:0] type_i,
   input  logic [NUM_PINS-1:0] pol_i,
   input  logic [NUM_PINS-1:0] both_i,
   input  logic [NUM_PINS-1:0] en_i,
   input  logic [NUM_PINS-1:0] clr_i,
   output logic [NUM_PINS-1:0] status_o
);

   logic [NUM_PINS-1:0] hit_v;
   logic [NUM_PINS-1:0] edge_q;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic rise, fall, edge_r;

      assign rise     = sync_i[i] & ~prev_i[i];
      assign fall     = ~sync_i[i] & prev_i[i];
      assign hit_v[i] = both_i[i] ? (rise | fall) : (pol_i[i] ? fall : rise);

      // a fresh edge outranks an acknowledge in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   edge_r <= 1'b0;
         else if (type_i[i])           edge_r <= 1'b0;
         else if (en_i[i] && hit_v[i]) edge_r <= 1'b1;
         else if (clr_i[i])            edge_r <= 1'b0;
      end

      assign edge_q[i]   = edge_r;
      assign status_o[i] = type_i[i] ? (en_i[i] & (sync_i[i] ^ pol_i[i])) : edge_r;
   end

   AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(edge_q) & ~$past(type_i) & ~$past(clr_i)) & ~edge_q) == '0)); // R7
   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(clr_i) & ~$past(hit_v & en_i) & edge_q) == '0)); // R9
   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((edge_q & ~$past(edge_q) & ~$past(en_i)) == '0)); // R10

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] sync_i,
   input  logic [NUM_PINS-1:0] status_i,
   output logic [NUM_PINS-1:0] out_q,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [NUM_PINS-1:0] en_q,
   output logic [NUM_PINS-1:0] mask_q,
   output logic [NUM_PINS-1:0] type_q,
   output logic [NUM_PINS-1:0] pol_q,
   output logic [NUM_PINS-1:0] both_q,
   output logic [NUM_PINS-1:0] clr_o
);

   gsel_e               sel;
   logic [NUM_PINS-1:0] wbits;
   logic [NUM_PINS-1:0] pen_q, ptyp_q, den_q;
   logic [DATA_W-1:0]   dpre_q;
   logic [NUM_PINS-1:0] rd_pins;
   logic [DATA_W-1:0]   rd_word;

   assign sel   = decode_addr(16'(bus_addr));
   assign wbits = bus_wdata[NUM_PINS-1:0];
   assign clr_o = (bus_we && sel == SEL_ICLR) ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '0;
         en_q   <= '0;
         mask_q <= '0;
         type_q <= '0;
         pol_q  <= '0;
         both_q <= '0;
         pen_q  <= '0;
         ptyp_q <= '0;
         den_q  <= '0;
         dpre_q <= '0;
      end else if (bus_we) begin
         case (sel)
            SEL_OUT:   out_q  <= wbits;
            SEL_SET:   out_q  <= out_q | wbits;
            SEL_CLR:   out_q  <= out_q & ~wbits;
            SEL_DIR:   dir_q  <= wbits;
            SEL_IEN:   en_q   <= wbits;
            SEL_IMASK: mask_q <= wbits;
            SEL_ITYPE: type_q <= wbits;
            SEL_IPOL:  pol_q  <= wbits;
            SEL_IBOTH: both_q <= wbits;
            SEL_PEN:   pen_q  <= wbits;
            SEL_PTYP:  ptyp_q <= wbits;
            SEL_DEN:   den_q  <= wbits;
            SEL_DPRE:  dpre_q <= bus_wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_pins = '0;
      rd_word = '0;
      case (sel)
         SEL_OUT:   rd_pins = out_q;
         SEL_IN:    rd_pins = sync_i;
         SEL_DIR:   rd_pins = dir_q;
         SEL_PEN:   rd_pins = pen_q;
         SEL_PTYP:  rd_pins = ptyp_q;
         SEL_IEN:   rd_pins = en_q;
         SEL_ISTAT: rd_pins = status_i;
         SEL_IMASK: rd_pins = mask_q;
         SEL_ITYPE: rd_pins = type_q;
         SEL_IBOTH: rd_pins = both_q;
         SEL_IPOL:  rd_pins = pol_q;
         SEL_DEN:   rd_pins = den_q;
         SEL_DPRE:  rd_word = dpre_q;
         default: ;
      endcase
      bus_rdata = rd_word | DATA_W'(rd_pins);
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> $stable(out_q)); // R2
   AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel == SEL_SET) |=> ((out_q & $past(wbits)) == $past(wbits))); // R3
   AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel == SEL_CLR) |=> ((out_q & $past(wbits)) == '0)); // R3

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
   parameter int NUM_PINS    = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq_out
);

   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("NUM_PINS must lie between 1 and DATA_W");
   end
   if (ADDR_W < 7 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie between 7 and 16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] sync_w, prev_w, status_w, clr_w;
   logic [NUM_PINS-1:0] out_w, dir_w, en_w, mask_w, type_w, pol_w, both_w;

   gpio_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_in),
      .sync_o (sync_w),
      .prev_o (prev_w)
   );

   gpio_regfile #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .sync_i    (sync_w),
      .status_i  (status_w),
      .out_q     (out_w),
      .dir_q     (dir_w),
      .en_q      (en_w),
      .mask_q    (mask_w),
      .type_q    (type_w),
      .pol_q     (pol_w),
      .both_q    (both_w),
      .clr_o     (clr_w)
   );

   gpio_trig_detect #(.NUM_PINS(NUM_PINS)) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_i   (sync_w),
      .prev_i   (prev_w),
      .type_i   (type_w),
      .pol_i    (pol_w),
      .both_i   (both_w),
      .en_i     (en_w),
      .clr_i    (clr_w),
      .status_o (status_w)
   );

   assign pin_out = out_w;
   assign pin_oe  = dir_w;
   assign irq_out = |(status_w & en_w & ~mask_w);

   AST_MASK_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_w) |-> !irq_out); // R11
   AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (status_w != '0)); // R11

endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe;
   logic        irq_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_irq_ctrl u_gpio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
   );

   // behavioural reference state
   logic [31:0] m_out, m_dir, m_pen, m_ptyp, m_en, m_mask, m_type, m_both, m_pol;
   logic [31:0] m_den, m_dpre, m_edge, m_s1, m_sync, m_prev;

   function automatic logic [31:0] mstat();
      return (m_en & m_type & (m_sync ^ m_pol)) | m_edge;
   endfunction

   function automatic logic [31:0] mread(input logic [7:0] a);
      case (a)
         8'h00: return m_out;
         8'h04: return m_sync;
         8'h08: return m_dir;
         8'h18: return m_pen;
         8'h1C: return m_ptyp;
         8'h20: return m_en;
         8'h24: return mstat();
         8'h2C: return m_mask;
         8'h34: return m_type;
         8'h38: return m_both;
         8'h3C: return m_pol;
         8'h40: return m_den;
         8'h44: return m_dpre;
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_out <= '0; m_dir <= '0; m_pen <= '0; m_ptyp <= '0; m_en <= '0;
         m_mask <= '0; m_type <= '0; m_both <= '0; m_pol <= '0; m_den <= '0;
         m_dpre <= '0; m_edge <= '0; m_s1 <= '0; m_sync <= '0; m_prev <= '0;
      end else begin
         logic [31:0] nxt;
         nxt = m_edge;
         for (int i = 0; i < 32; i++) begin
            bit up, dn, trig;
            up   = m_sync[i] && !m_prev[i];
            dn   = !m_sync[i] && m_prev[i];
            trig = m_both[i] ? (up || dn) : (m_pol[i] ? dn : up);
            if (m_type[i])                nxt[i] = 1'b0;
            else if (m_en[i] && trig)     nxt[i] = 1'b1;
            else if (bus_we && bus_addr == 8'h30 && bus_wdata[i]) nxt[i] = 1'b0;
         end
         m_edge <= nxt;
         m_s1   <= pin_in;
         m_sync <= m_s1;
         m_prev <= m_sync;
         if (bus_we) begin
            case (bus_addr)
               8'h00: m_out  <= bus_wdata;
               8'h10: m_out  <= m_out | bus_wdata;
               8'h14: m_out  <= m_out & ~bus_wdata;
               8'h08: m_dir  <= bus_wdata;
               8'h18: m_pen  <= bus_wdata;
               8'h1C: m_ptyp <= bus_wdata;
               8'h20: m_en   <= bus_wdata;
               8'h2C: m_mask <= bus_wdata;
               8'h34: m_type <= bus_wdata;
               8'h38: m_both <= bus_wdata;
               8'h3C: m_pol  <= bus_wdata;
               8'h40: m_den  <= bus_wdata;
               8'h44: m_dpre <= bus_wdata;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the reference, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 per-cycle read data", bus_rdata, mread(bus_addr));
         chk("R11 per-cycle irq_out", {31'b0, irq_out}, {31'b0, |(mstat() & m_en & ~m_mask)});
         chk("R3 per-cycle pin_out", pin_out, m_out);
         chk("R4 per-cycle pin_oe", pin_oe, m_dir);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(posedge clk); #1;
      bus_addr = a; bus_we = 1'b0;
      @(negedge clk);
      chk(tag, bus_rdata, exp);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(8'h00, 0, "R1 output data after reset");
      rd(8'h08, 0, "R1 direction after reset");
      rd(8'h20, 0, "R1 enable after reset");
      rd(8'h24, 0, "R1 status after reset");
      rd(8'h2C, 0, "R1 mask after reset");
      rd(8'h34, 0, "R1 trigger type after reset");
      chk("R1 irq_out after reset", {31'b0, irq_out}, 0);

      // R2 / R3 output word and aliases
      wr(8'h00, 32'hA5A5_0F0F);
      rd(8'h00, 32'hA5A5_0F0F, "R2 output word readback");
      chk("R3 pin_out follows output word", pin_out, 32'hA5A5_0F0F);
      wr(8'h10, 32'h0000_F0F0);
      rd(8'h00, 32'hA5A5_FFFF, "R3 set alias");
      wr(8'h14, 32'hA000_000F);
      rd(8'h00, 32'h05A5_FFF0, "R3 clear alias");
      rd(8'h10, 0, "R12 set alias reads zero");
      rd(8'h14, 0, "R12 clear alias reads zero");

      // R4 direction
      wr(8'h08, 32'hFFFF_0000);
      chk("R4 pin_oe follows direction", pin_oe, 32'hFFFF_0000);

      // R5 synchronizer latency, all pins regardless of direction
      @(posedge clk); #1;
      bus_addr = 8'h04; pin_in = 32'h1234_5678;
      @(negedge clk);
      @(negedge clk);
      chk("R5 input not visible after one edge", bus_rdata, 0);
      @(negedge clk);
      chk("R5 input visible after two edges", bus_rdata, 32'h1234_5678);
      pin_in = '0;
      cyc(4);

      // interrupt configuration
      wr(8'h20, 32'h0000_00FF);
      wr(8'h34, 32'h0000_0003);
      wr(8'h3C, 32'h0000_001A);
      wr(8'h38, 32'h0000_0010);
      rd(8'h24, 32'h2, "R6 active-low level pin reports at low input");
      chk("R11 irq_out from level status", {31'b0, irq_out}, 1);
      pin_in = 32'h1; cyc(3);
      rd(8'h24, 32'h3, "R6 active-high level pin reports at high input");
      pin_in = 32'h2; cyc(3);
      rd(8'h24, 32'h0, "R6 level status not held");

      pin_in = 32'h11E; cyc(4);
      rd(8'h24, 32'h14, "R7 R8 R10 rising edges latched on enabled pins");
      pin_in = 32'h2; cyc(4);
      rd(8'h24, 32'h1C, "R7 falling edge latched, rising held, R8 any edge");
      wr(8'h30, 32'h0);
      rd(8'h24, 32'h1C, "R9 writing zero to clear has no effect");
      wr(8'h30, 32'h4);
      rd(8'h24, 32'h18, "R9 clear one latched pin");
      wr(8'h30, 32'h18);
      rd(8'h24, 32'h0, "R9 clear remaining pins");
      wr(8'h20, 32'h0000_01FF);
      rd(8'h24, 32'h0, "R10 edge seen while disabled not reported");

      // R11 mask
      pin_in = 32'h22; cyc(4);
      rd(8'h24, 32'h20, "R11 status before mask");
      chk("R11 irq_out unmasked", {31'b0, irq_out}, 1);
      wr(8'h2C, 32'h20);
      rd(8'h24, 32'h20, "R11 masked status still readable");
      chk("R11 irq_out masked", {31'b0, irq_out}, 0);
      wr(8'h2C, 32'h0);
      rd(8'h24, 32'h20, "R11 status after unmask");
      chk("R11 irq_out after unmask", {31'b0, irq_out}, 1);
      wr(8'h30, 32'h20);
      pin_in = 32'h2; cyc(4);
      rd(8'h24, 32'h0, "R9 cleared, falling input ignored in rising mode");

      // R9 edge and clear in the same cycle
      @(posedge clk); #1;
      pin_in = 32'h22;
      @(posedge clk);
      @(posedge clk); #1;
      bus_addr = 8'h30; bus_we = 1'b1; bus_wdata = 32'h20;
      @(posedge clk); #1;
      bus_we = 1'b0;
      rd(8'h24, 32'h20, "R9 new edge wins over same-cycle clear");
      rd(8'h30, 0, "R12 interrupt clear reads zero");
      wr(8'h30, 32'h20);
      rd(8'h24, 32'h0, "R9 clear after collision");

      // R12 storage-only words
      wr(8'h18, 32'hDEAD_BEEF);
      wr(8'h1C, 32'h0F0F_0F0F);
      wr(8'h40, 32'h1234_5678);
      wr(8'h44, 32'hCAFE_0001);
      rd(8'h18, 32'hDEAD_BEEF, "R12 pull enable storage");
      rd(8'h1C, 32'h0F0F_0F0F, "R12 pull type storage");
      rd(8'h40, 32'h1234_5678, "R12 debounce enable storage");
      rd(8'h44, 32'hCAFE_0001, "R12 debounce prescale storage");
      chk("R12 pin_out unaffected", pin_out, 32'h05A5_FFF0);
      chk("R12 pin_oe unaffected", pin_oe, 32'hFFFF_0000);
      rd(8'h24, 32'h0, "R12 status unaffected");
      chk("R12 irq_out unaffected", {31'b0, irq_out}, 0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule